// File: doc/BRIEF.md
# Four-Channel Serial DAC Register Front End

This block holds the digital state behind a four-channel, 16-bit converter that is written over a three-wire serial link. Serial words enter a 24-bit shift register, clocked on each rising edge of the OR of the select and serial-clock lines. The oldest bit of that register leaves on the serial output, so several such blocks can be cascaded. Each frame carries a two-bit channel address in its top bits, a broadcast flag below them and the 16-bit code in its low bits.

A low level on the active-low load line, while select is high, makes the addressed staging register follow the code field of the shift register. When the broadcast flag is set, all four staging registers follow it. A rising edge on the transfer line then copies all four staging registers into the four output code registers in the same cycle. A rising edge on the clear line forces all eight registers to half-scale or to zero, chosen by the clear-select level. The shift register keeps its contents through a clear.

All asynchronous pins are brought into one fast system clock through two-flop synchronisers, and edges are found by comparing synchronised samples. A synchronous power-on reset puts the code registers at the clear-select code and empties the shift register.

Top module: `quad_dac_ctrl`

## Requirements
- R1: The shift register moves one place toward its top on every rising edge of (ser_sel OR ser_clk) and takes ser_din into bit 0. A frame is 24 bits, sent most significant bit first. A rise of ser_sel while ser_clk is low is such an edge and shifts one extra bit.
- R2: ser_dout always equals bit 23 of the shift register, so the bits of an earlier frame leave in the order they arrived.
- R3: While load_n is low and ser_sel is high, with frame bit 21 clear, only the staging register addressed by frame bits 23:22 (0 selects channel 0, 3 selects channel 3) follows frame bits 15:0. The other staging registers keep their values. Bits 20:16 are ignored.
- R4: When frame bit 21 is set under the same load condition, all four staging registers follow frame bits 15:0.
- R5: On a rising edge of xfer with load_n high, all four output codes take their staging values in the same cycle. Without such an edge the output codes hold.
- R6: A rising edge of xfer while load_n is low leaves all output codes unchanged.
- R7: On a rising edge of clr, all staging and output registers become 0x8000 if clr_mid is high, or 0x0000 if it is low.
- R8: A clr edge leaves the shift register contents unchanged. A later load and transfer therefore still deliver the frame shifted before the clear.
- R9: While rst_n is low, all staging and output registers take 0x8000 if clr_mid is high and 0x0000 otherwise, and the shift register becomes zero (ser_dout low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every serial and control pin |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| ser_sel | input | 1 | Select line, ORed with ser_clk to form the shift clock |
| ser_clk | input | 1 | Serial bit clock |
| ser_din | input | 1 | Serial data in |
| load_n | input | 1 | Active-low level strobe into the staging registers |
| xfer | input | 1 | Rising edge copies staging registers to output codes |
| clr | input | 1 | Rising edge clears all code registers |
| clr_mid | input | 1 | Clear code select: high gives half-scale, low gives zero |
| ser_dout | output | 1 | Last shift-register stage, used for cascading |
| dac_code | output | 64 | Four output codes, channel c at bits 16c+15:16c |

## Verification
The hardest state to reach is a shift register that still holds a valid frame after a clear. A clear resets every visible register, so the frame can only be seen again through a later load and transfer. The stimulus shifts a frame without loading it, pulses clr, checks that the outputs went to the clear code, then loads and transfers and expects the earlier frame's code on the addressed channel. The extra shift caused by ser_sel rising over a low ser_clk is reached by sending 23 clocked bits and letting the select rise deliver the 24th.

// File: rtl/quad_dac_pkg.sv
package quad_dac_pkg;
    parameter int CODE_W      = 16;
    parameter int NUM_CH      = 4;
    parameter int FRAME_W     = 24;
    parameter int ADDR_W      = 2;
    parameter int BCAST_BIT   = 21;
    parameter int SYNC_STAGES = 2;

    // lane numbering of the synchroniser front end
    localparam int LN_SCK = 0;
    localparam int LN_SEL = 1;
    localparam int LN_DIN = 2;
    localparam int LN_LDN = 3;
    localparam int LN_XFR = 4;
    localparam int LN_CLR = 5;
    localparam int LN_MID = 6;
    localparam int NUM_LANES = 7;

    // idle levels: clocks and select high, load_n high, the rest low
    localparam logic [NUM_LANES-1:0] LANE_IDLE = 7'b000_1011;
endpackage

// File: rtl/qd_front.sv
module qd_front #(
    parameter int NB     = quad_dac_pkg::NUM_LANES,
    parameter int STAGES = quad_dac_pkg::SYNC_STAGES,
    parameter logic [NB-1:0] IDLE = quad_dac_pkg::LANE_IDLE
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NB-1:0] raw,
    output logic [NB-1:0] lvl,
    output logic [NB-1:0] rise
);
    typedef struct packed {
        logic [STAGES-1:0][NB-1:0] pipe;
        logic [NB-1:0]             prev;
    } front_t;

    front_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.pipe[0] = raw;
        for (int s = 1; s < STAGES; s++) begin
            st_d.pipe[s] = st_q.pipe[s-1];
        end
        st_d.prev = st_q.pipe[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) st_q.pipe[s] <= IDLE;
            st_q.prev <= IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign lvl  = st_q.pipe[STAGES-1];
    assign rise = st_q.pipe[STAGES-1] & ~st_q.prev;
endmodule

// File: rtl/qd_shifter.sv
module qd_shifter #(
    parameter int FRAME_W = quad_dac_pkg::FRAME_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel_lvl,
    input  logic               sck_lvl,
    input  logic               din_lvl,
    output logic [FRAME_W-1:0] frame,
    output logic               dout
);
    typedef struct packed {
        logic [FRAME_W-1:0] sr;
        logic               prev_or;
    } shf_t;

    shf_t st_d, st_q;
    logic shclk;
    logic step;

    assign shclk = sel_lvl | sck_lvl;
    assign step  = shclk & ~st_q.prev_or;

    always_comb begin
        st_d = st_q;
        st_d.prev_or = shclk;
        if (step) begin
            st_d.sr = {st_q.sr[FRAME_W-2:0], din_lvl};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.sr      <= '0;
            st_q.prev_or <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign frame = st_q.sr;
    assign dout  = st_q.sr[FRAME_W-1];

    // R1: a shift edge moves the top-but-one stage into the top
    p_shift_move_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (shclk && !st_q.prev_or) |=> dout == $past(st_q.sr[FRAME_W-2]));
    // R8: no shift edge, no change of the frame
    p_frame_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(shclk && !st_q.prev_or) |=> $stable(frame));
endmodule

// File: rtl/qd_chan_bank.sv
module qd_chan_bank #(
    parameter int CODE_W    = quad_dac_pkg::CODE_W,
    parameter int NUM_CH    = quad_dac_pkg::NUM_CH,
    parameter int FRAME_W   = quad_dac_pkg::FRAME_W,
    parameter int ADDR_W    = quad_dac_pkg::ADDR_W,
    parameter int BCAST_BIT = quad_dac_pkg::BCAST_BIT
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     por_mid,
    input  logic [FRAME_W-1:0]       frame,
    input  logic                     load_en,
    input  logic                     xfer_go,
    input  logic                     clr_go,
    input  logic                     clr_mid,
    output logic [NUM_CH*CODE_W-1:0] codes
);
    localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);

    typedef struct packed {
        logic [NUM_CH-1:0][CODE_W-1:0] stage;
        logic [NUM_CH-1:0][CODE_W-1:0] dac;
    } bank_t;

    bank_t st_d, st_q;
    logic [NUM_CH-1:0] hit;
    logic [CODE_W-1:0] clr_val;
    logic [CODE_W-1:0] por_val;

    assign clr_val = clr_mid ? MID_CODE : '0;
    assign por_val = por_mid ? MID_CODE : '0;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign hit[c] = frame[BCAST_BIT] |
                        (frame[FRAME_W-1 -: ADDR_W] == ADDR_W'(c));
        assign codes[c*CODE_W +: CODE_W] = st_q.dac[c];

        // R7: a clear puts both registers of the channel at the chosen code
        p_clr_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
            clr_go |=> (st_q.stage[c] == $past(clr_val)) &&
                       (st_q.dac[c] == $past(clr_val)));
        // R4: broadcast load reaches every channel
        p_bcast_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (load_en && frame[BCAST_BIT] && !clr_go) |=>
                st_q.stage[c] == $past(frame[CODE_W-1:0]));
        // R5: transfer copies staging into output
        p_xfer_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (xfer_go && !clr_go) |=> st_q.dac[c] == $past(st_q.stage[c]));
        // R5: without transfer or clear the output holds
        p_dac_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (!xfer_go && !clr_go) |=> $stable(st_q.dac[c]));
    end

    always_comb begin
        st_d = st_q;
        if (clr_go) begin
            for (int c = 0; c < NUM_CH; c++) begin
                st_d.stage[c] = clr_val;
                st_d.dac[c]   = clr_val;
            end
        end else begin
            if (load_en) begin
                for (int c = 0; c < NUM_CH; c++) begin
                    if (hit[c]) st_d.stage[c] = frame[CODE_W-1:0];
                end
            end
            if (xfer_go) begin
                st_d.dac = st_q.stage;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NUM_CH; c++) begin
                st_q.stage[c] <= por_val;
                st_q.dac[c]   <= por_val;
            end
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/quad_dac_ctrl.sv
module quad_dac_ctrl #(
    parameter int CODE_W  = quad_dac_pkg::CODE_W,
    parameter int NUM_CH  = quad_dac_pkg::NUM_CH,
    parameter int FRAME_W = quad_dac_pkg::FRAME_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ser_sel,
    input  logic                     ser_clk,
    input  logic                     ser_din,
    input  logic                     load_n,
    input  logic                     xfer,
    input  logic                     clr,
    input  logic                     clr_mid,
    output logic                     ser_dout,
    output logic [NUM_CH*CODE_W-1:0] dac_code
);
    import quad_dac_pkg::*;

    logic [NUM_LANES-1:0] raw, lvl, rise;
    logic [FRAME_W-1:0]   frame;
    logic                 load_en, xfer_go, clr_go;

    always_comb begin
        raw         = '0;
        raw[LN_SCK] = ser_clk;
        raw[LN_SEL] = ser_sel;
        raw[LN_DIN] = ser_din;
        raw[LN_LDN] = load_n;
        raw[LN_XFR] = xfer;
        raw[LN_CLR] = clr;
        raw[LN_MID] = clr_mid;
    end

    qd_front #(.NB(NUM_LANES), .STAGES(SYNC_STAGES), .IDLE(LANE_IDLE)) front_i (
        .clk(clk), .rst_n(rst_n), .raw(raw), .lvl(lvl), .rise(rise));

    qd_shifter #(.FRAME_W(FRAME_W)) shf_i (
        .clk(clk), .rst_n(rst_n),
        .sel_lvl(lvl[LN_SEL]), .sck_lvl(lvl[LN_SCK]), .din_lvl(lvl[LN_DIN]),
        .frame(frame), .dout(ser_dout));

    assign load_en = ~lvl[LN_LDN] & lvl[LN_SEL];
    assign xfer_go = rise[LN_XFR] & lvl[LN_LDN];
    assign clr_go  = rise[LN_CLR];

    qd_chan_bank #(.CODE_W(CODE_W), .NUM_CH(NUM_CH), .FRAME_W(FRAME_W),
                   .ADDR_W(ADDR_W), .BCAST_BIT(BCAST_BIT)) bank_i (
        .clk(clk), .rst_n(rst_n), .por_mid(clr_mid), .frame(frame),
        .load_en(load_en), .xfer_go(xfer_go), .clr_go(clr_go),
        .clr_mid(lvl[LN_MID]), .codes(dac_code));

    // R6: a transfer edge seen while load is low never moves the outputs
    p_xfer_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rise[LN_XFR] && !lvl[LN_LDN] && !clr_go) |=> $stable(dac_code));
endmodule

// File: tb/quad_dac_ctrl_tb_top.sv
module quad_dac_ctrl_tb_top;
    localparam int SP = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_sel = 1'b1, ser_clk = 1'b1, ser_din = 1'b0;
    logic load_n = 1'b1, xfer = 1'b0, clr = 1'b0, clr_mid = 1'b1;
    logic ser_dout;
    logic [63:0] dac_code;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [23:0] m_sr;
    logic [15:0] m_stg [4];
    logic [15:0] m_dac [4];

    always #10 clk = ~clk;

    quad_dac_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .ser_sel(ser_sel), .ser_clk(ser_clk),
        .ser_din(ser_din), .load_n(load_n), .xfer(xfer), .clr(clr),
        .clr_mid(clr_mid), .ser_dout(ser_dout), .dac_code(dac_code));

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_dacs(input string tag);
        idle(6);
        for (int c = 0; c < 4; c++) chk(tag, 32'(dac_code[c*16 +: 16]), 32'(m_dac[c]));
    endtask

    function automatic logic [23:0] mk(input logic [1:0] a, input logic q, input logic [15:0] d);
        return {a, q, 5'b10110, d};
    endfunction

    task automatic por(input logic mid);
        clr_mid = mid;
        rst_n = 1'b0;
        idle(4);
        rst_n = 1'b1;
        m_sr = '0;
        for (int c = 0; c < 4; c++) begin
            m_stg[c] = mid ? 16'h8000 : 16'h0000;
            m_dac[c] = m_stg[c];
        end
        idle(8);
    endtask

    task automatic send_frame(input logic [23:0] f, input bit sel_last, input bit chk_out);
        ser_sel = 1'b0;
        idle(SP);
        for (int i = 23; i >= 0; i--) begin
            if (chk_out) chk("R2 cascade output", 32'(ser_dout), 32'(m_sr[23]));
            ser_clk = 1'b0;
            ser_din = f[i];
            idle(SP);
            if (i == 0 && sel_last) begin
                ser_sel = 1'b1;
                idle(SP);
                ser_clk = 1'b1;
            end else begin
                ser_clk = 1'b1;
                idle(SP);
            end
            m_sr = {m_sr[22:0], f[i]};
        end
        ser_sel = 1'b1;
        idle(SP);
    endtask

    task automatic load_pulse();
        load_n = 1'b0;
        idle(2 * SP);
        load_n = 1'b1;
        idle(SP);
        for (int c = 0; c < 4; c++)
            if (m_sr[21] || m_sr[23:22] == 2'(c)) m_stg[c] = m_sr[15:0];
    endtask

    task automatic xfer_pulse();
        xfer = 1'b1;
        idle(SP);
        xfer = 1'b0;
        idle(SP);
        for (int c = 0; c < 4; c++) m_dac[c] = m_stg[c];
    endtask

    task automatic clr_pulse(input logic mid);
        clr_mid = mid;
        idle(SP);
        clr = 1'b1;
        idle(SP);
        clr = 1'b0;
        idle(SP);
        for (int c = 0; c < 4; c++) begin
            m_stg[c] = mid ? 16'h8000 : 16'h0000;
            m_dac[c] = m_stg[c];
        end
    endtask

    task automatic t_reset_mid();
        por(1'b1);
        chk("R9 shift reg empty", 32'(ser_dout), 32'h0);
        chk_dacs("R9 reset half-scale");
    endtask

    task automatic t_per_channel();
        logic [15:0] vals [4];
        vals[0] = 16'h1234; vals[1] = 16'hBEEF; vals[2] = 16'h0001; vals[3] = 16'hFFFF;
        for (int c = 0; c < 4; c++) begin
            send_frame(mk(2'(c), 1'b0, vals[c]), 1'b0, 1'b0);
            load_pulse();
        end
        chk_dacs("R5 outputs hold before transfer");
        xfer_pulse();
        chk_dacs("R3 per-channel address");
        chk("R3 channel 2 code", 32'(dac_code[47:32]), 32'h0001);
    endtask

    task automatic t_broadcast();
        send_frame(mk(2'd1, 1'b1, 16'hA5C3), 1'b0, 1'b0);
        load_pulse();
        xfer_pulse();
        chk_dacs("R4 broadcast load");
        chk("R4 channel 3 code", 32'(dac_code[63:48]), 32'hA5C3);
    endtask

    task automatic t_xfer_blocked();
        send_frame(mk(2'd0, 1'b0, 16'h7777), 1'b0, 1'b0);
        load_n = 1'b0;
        idle(SP);
        xfer = 1'b1;
        idle(SP);
        xfer = 1'b0;
        idle(SP);
        load_n = 1'b1;
        idle(SP);
        m_stg[0] = 16'h7777;
        chk_dacs("R6 transfer with load low ignored");
        xfer_pulse();
        chk_dacs("R5 later transfer delivers staged code");
    endtask

    task automatic t_clear_keeps_frame();
        send_frame(mk(2'd2, 1'b0, 16'h4C1D), 1'b0, 1'b0);
        clr_pulse(1'b0);
        chk_dacs("R7 clear to zero");
        load_pulse();
        xfer_pulse();
        chk("R8 frame survives clear", 32'(dac_code[47:32]), 32'h4C1D);
        clr_pulse(1'b1);
        chk_dacs("R7 clear to half-scale");
    endtask

    task automatic t_extra_shift();
        send_frame(mk(2'd3, 1'b0, 16'h0F0F), 1'b0, 1'b0);
        send_frame(mk(2'd1, 1'b0, 16'h3C3D), 1'b1, 1'b0);
        load_pulse();
        xfer_pulse();
        chk("R1 select rise shifts last bit", 32'(dac_code[31:16]), 32'h3C3D);
        chk_dacs("R1 extra shift frame");
    endtask

    task automatic t_cascade();
        send_frame(mk(2'd2, 1'b1, 16'h9ABC), 1'b0, 1'b0);
        send_frame(mk(2'd0, 1'b0, 16'h5555), 1'b0, 1'b1);
        chk("R2 last stage after frame", 32'(ser_dout), 32'(m_sr[23]));
    endtask

    task automatic t_reset_zero();
        por(1'b0);
        chk("R9 shift reg empty after zero reset", 32'(ser_dout), 32'h0);
        chk_dacs("R9 reset zero");
    endtask

    initial begin
        t_reset_mid();
        t_per_channel();
        t_broadcast();
        t_xfer_blocked();
        t_clear_keeps_frame();
        t_extra_shift();
        t_cascade();
        t_reset_zero();
        if (!done) begin
            done = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule